// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets a host controller read and write a bank of byte-wide configuration registers. The register count defaults to 32. Every transaction is framed by an active-low chip select. It opens with an eight-bit command byte, which gives the direction, the number of data bytes (one to four) and the first register address. The data bytes follow the command byte. For each further byte the address steps up by one, and after the last register it wraps to zero.

The port runs entirely on the system clock `clk`. The serial clock, chip select and serial input are sampled by `clk`, and their edges are detected inside the block. The core logic reads any register through a registered parallel port, one cycle after it presents the address. It also sees register 0 directly, because register 0 holds the port's own settings. Bit 7 of register 0 chooses where read data leaves the block: the dedicated output pin, or the shared data pin when the bus runs in three-wire mode. Bit 6 of register 0 chooses least-significant-bit-first order. Each data pin has its own output-enable, which an external pad uses to build a tri-state buffer.

Top module: `spi_cfg_port`

## Requirements
- R1: The first eight serial-clock rising edges after chip select falls form the command byte. Command bit 7 set to 1 starts a read and set to 0 starts a write.
- R2: Command bits 6:5 hold the data length minus one: 00 means one byte and 11 means four bytes. After that many bytes, further serial-clock edges are ignored until chip select rises.
- R3: Command bits 4:0 give the first register address. Each following byte uses the next address, and the address wraps from 31 to 0.
- R4: Input bits are taken on serial-clock rising edges, and read bits change after falling edges. The first read bit appears after the falling edge that follows the eighth command rising edge. Both output-enables drop at the falling edge after the final data bit.
- R5: Register 0 bit 6 set to 1 selects LSB-first order for both the command byte and the data bytes. A value written to it applies from the next transaction on. After reset the order is MSB-first.
- R6: When chip select goes high, the transaction aborts. A partly shifted byte is never written, and the next low chip select starts a fresh command byte.
- R7: A written byte lands in its register as soon as its eighth bit is taken, while chip select is still low.
- R8: While chip select is high, `sdio_oe` and `sdo_oe` are both 0.
- R9: With register 0 bit 7 at 0, read data is driven on `sdo_out` under `sdo_oe`. With the bit at 1, read data is driven on `sdio_out` under `sdio_oe`. The two enables are never 1 together.
- R10: `core_rdata` returns the register at `core_addr` one clock later. After reset, register 0 reads 0 and `cfg_ctrl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and sampling |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data input (pad receive side) |
| sdio_out | output | 1 | Read data toward the shared data pin |
| sdio_oe | output | 1 | Drive enable of the shared data pin |
| sdo_out | output | 1 | Read data toward the dedicated output pin |
| sdo_oe | output | 1 | Drive enable of the dedicated output pin |
| core_addr | input | 5 | Core-side register read address |
| core_rdata | output | 8 | Core-side read data, one clock latency |
| cfg_ctrl | output | 8 | Live contents of register 0 |

## Verification
The embedded assertions check five properties on every clock:
- the two enables are never active together;
- deselection clears the drive and rewinds the command phase;
- no write occurs during a read or after the data phase has finished;
- the drive never starts outside a read data phase;
- a write to register 0 appears on `cfg_ctrl` one clock later.

The bench scenarios cover what only a full transaction reveals:
- the bit order on the wire and the address sequence with wrap;
- per-byte commit while chip select is still low;
- discarding of aborted bytes and of excess clocks;
- the one-transaction delay before a new bit order takes effect.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  // command byte field positions (decoded by the sequencer)
  localparam int CMD_DIR_BIT  = 7;
  localparam int CMD_LEN_HI   = 6;
  localparam int CMD_LEN_LO   = 5;
  localparam int CMD_ADDR_W   = 5;
  // register 0 control bits
  localparam int CTL_3WIRE_BIT = 7;
  localparam int CTL_LSB_BIT   = 6;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_END  = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic sdi_s
);
  logic sclk_s1, sclk_s2, cs_s1, sdi_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s1 <= 1'b0;
      sclk_s2 <= 1'b0;
      cs_s1   <= 1'b1;
      sdi_s1  <= 1'b0;
    end else begin
      sclk_s1 <= sclk;
      sclk_s2 <= sclk_s1;
      cs_s1   <= cs_n;
      sdi_s1  <= sdi;
    end
  end

  assign sclk_rise = sclk_s1 & ~sclk_s2;
  assign sclk_fall = ~sclk_s1 & sclk_s2;
  assign cs_idle   = cs_s1;
  assign sdi_s     = sdi_s1;
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_cfg_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_idle,
  input  logic              sdi,
  input  logic              lsb_cfg,
  input  logic [7:0]        rd_data,
  input  logic              rd_vld,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output logic              oe
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);

  phase_t            phase_q;
  logic [2:0]        bit_q;
  logic [1:0]        left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic              lsb_q;
  logic [7:0]        sh_in_q;
  logic [7:0]        sh_out_q;
  logic [7:0]        byte_nxt;
  logic [ADDR_W-1:0] addr_inc;

  assign byte_nxt = lsb_q ? {sdi, sh_in_q[7:1]} : {sh_in_q[6:0], sdi};
  assign addr_inc = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_CMD;
      bit_q    <= '0;
      left_q   <= '0;
      addr_q   <= '0;
      rw_q     <= 1'b0;
      lsb_q    <= 1'b0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      if (cs_idle) begin
        phase_q <= PH_CMD;
        bit_q   <= '0;
        oe      <= 1'b0;
        lsb_q   <= lsb_cfg;
      end else begin
        if (sclk_rise) begin
          case (phase_q)
            PH_CMD: begin
              sh_in_q <= byte_nxt;
              bit_q   <= bit_q + 1'b1;
              if (bit_q == 3'd7) begin
                rw_q    <= byte_nxt[CMD_DIR_BIT];
                left_q  <= byte_nxt[CMD_LEN_HI:CMD_LEN_LO];
                addr_q  <= byte_nxt[ADDR_W-1:0];
                phase_q <= PH_DATA;
                if (byte_nxt[CMD_DIR_BIT]) begin
                  rd_req  <= 1'b1;
                  rd_addr <= byte_nxt[ADDR_W-1:0];
                end
              end
            end
            PH_DATA: begin
              sh_in_q <= byte_nxt;
              bit_q   <= bit_q + 1'b1;
              if (bit_q == 3'd7) begin
                if (!rw_q) begin
                  wr_en   <= 1'b1;
                  wr_addr <= addr_q;
                  wr_data <= byte_nxt;
                end
                addr_q <= addr_inc;
                if (left_q == 2'd0) begin
                  phase_q <= PH_END;
                end else begin
                  left_q <= left_q - 1'b1;
                  if (rw_q) begin
                    rd_req  <= 1'b1;
                    rd_addr <= addr_inc;
                  end
                end
              end
            end
            default: ;
          endcase
        end
        if (sclk_fall) begin
          if (phase_q == PH_DATA && rw_q) begin
            oe       <= 1'b1;
            dout     <= lsb_q ? sh_out_q[0] : sh_out_q[7];
            sh_out_q <= lsb_q ? {1'b0, sh_out_q[7:1]} : {sh_out_q[6:0], 1'b0};
          end else begin
            oe <= 1'b0;
          end
        end
        if (rd_vld) sh_out_q <= rd_data;
      end
    end
  end

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (phase_q == PH_CMD && bit_q == 3'd0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !oe); // R8
  AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rw_q); // R1
  AST_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (rw_q && phase_q != PH_CMD)); // R4
  AST_END_SILENT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_END) |=> !wr_en); // R2
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile #(
  parameter int NREG   = 32,
  parameter int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_vld,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [7:0]        core_rdata,
  output logic [7:0]        cfg_ctrl
);
  logic [7:0] mem [NREG];
  logic [7:0] ctrl_q;
  logic [7:0] rd_raw_q, core_raw_q;
  logic       rd_sel0_q, core_sel0_q;

  // memory array: no reset, registered reads (block RAM friendly)
  always_ff @(posedge clk) begin
    if (wr_en && wr_addr != '0) mem[wr_addr] <= wr_data;
    rd_raw_q    <= mem[rd_addr];
    core_raw_q  <= mem[core_addr];
    rd_sel0_q   <= (rd_addr == '0);
    core_sel0_q <= (core_addr == '0);
  end

  // register 0 lives in flops so it resets and is visible at once
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= rd_req;
      if (wr_en && wr_addr == '0) ctrl_q <= wr_data;
    end
  end

  assign rd_data    = rd_sel0_q   ? ctrl_q : rd_raw_q;
  assign core_rdata = core_sel0_q ? ctrl_q : core_raw_q;
  assign cfg_ctrl   = ctrl_q;

  AST_CTRL_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> (cfg_ctrl == $past(wr_data))); // R7
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [7:0]        core_rdata,
  output logic [7:0]        cfg_ctrl
);
  logic sclk_rise, sclk_fall, cs_idle, sdi_s;
  logic wr_en, rd_req, rd_vld, dout, oe;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  spi_pin_sampler u_pins (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdio_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle), .sdi_s(sdi_s)
  );

  spi_xfer_seq #(.NREG(NREG), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .sdi(sdi_s), .lsb_cfg(cfg_ctrl[CTL_LSB_BIT]),
    .rd_data(rd_data), .rd_vld(rd_vld), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .dout(dout), .oe(oe)
  );

  spi_cfg_regfile #(.NREG(NREG), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld),
    .core_addr(core_addr), .core_rdata(core_rdata), .cfg_ctrl(cfg_ctrl)
  );

  assign sdio_out = dout;
  assign sdo_out  = dout;
  assign sdio_oe  = oe &  cfg_ctrl[CTL_3WIRE_BIT];
  assign sdo_oe   = oe & ~cfg_ctrl[CTL_3WIRE_BIT];

  AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe)); // R9
endmodule

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdio_in = 1'b0;
  logic [4:0] core_addr = '0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;
  logic [7:0] core_rdata, cfg_ctrl;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] model [32];

  always #5 clk = ~clk;

  spi_cfg_port u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .core_addr(core_addr), .core_rdata(core_rdata), .cfg_ctrl(cfg_ctrl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdio_in = b;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, input logic lsb);
    for (int i = 0; i < 8; i++) put_bit(lsb ? v[i] : v[7-i]);
  endtask

  task automatic get_byte(input logic lsb, input logic three, output logic [7:0] v);
    logic en_ok;
    en_ok = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      repeat (7) @(negedge clk);
      v[lsb ? i : 7-i] = three ? sdio_out : sdo_out;
      if (three ? !(sdio_oe && !sdo_oe) : !(sdo_oe && !sdio_oe)) en_ok = 1'b0;
      @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    chk("R9 data pin and enable choice", en_ok, 1);
  endtask

  task automatic core_get(input logic [4:0] a, output logic [7:0] v);
    core_addr = a;
    @(negedge clk);
    @(negedge clk);
    v = core_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] n, input logic [31:0] d,
                    input logic lsb);
    sel();
    put_byte({1'b0, n, a}, lsb);
    for (int k = 0; k <= int'(n); k++) begin
      put_byte(d[8*k +: 8], lsb);
      model[5'(int'(a) + k)] = d[8*k +: 8];
    end
    desel();
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [1:0] n, input logic lsb,
                        input logic three);
    logic [7:0] got;
    sel();
    put_byte({1'b1, n, a}, lsb);
    for (int k = 0; k <= int'(n); k++) begin
      get_byte(lsb, three, got);
      chk("R3 R1 read byte at stepped address", got, model[5'(int'(a) + k)]);
    end
    repeat (4) @(negedge clk);
    chk("R4 enables released after final bit", {sdio_oe, sdo_oe}, 0);
    desel();
  endtask

  task automatic read_sweep(input logic lsb, input logic three);
    int starts [5] = '{0, 7, 29, 30, 31};
    for (int s = 0; s < 5; s++)
      for (int n = 0; n < 4; n++)
        rd_chk(5'(starts[s]), 2'(n), lsb, three);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R10 / R8 reset state
    core_get(5'd0, v);
    chk("R10 register 0 after reset", v, 8'h00);
    chk("R10 cfg_ctrl after reset", cfg_ctrl, 8'h00);
    chk("R8 enables idle after reset", {sdio_oe, sdo_oe}, 0);

    // R1 R3 R10: single-byte write to every address, read back on core port
    for (int a = 0; a < 32; a++) wr(5'(a), 2'd0, 32'((a * 37 + 11) & 8'hFF), 1'b0);
    for (int a = 0; a < 32; a++) begin
      core_get(5'(a), v);
      chk("R10 R3 core readback after write", v, 8'((a * 37 + 11) & 8'hFF));
    end

    // R2 R3 R4: reads of every length, four-wire, MSB-first, with wrap
    read_sweep(1'b0, 1'b0);

    // R3 wrapping four-byte write 30,31,0,1
    wr(5'd30, 2'd3, 32'h0837_2615, 1'b0);
    for (int k = 0; k < 4; k++) begin
      core_get(5'(30 + k), v);
      chk("R3 wrapped multibyte write", v, model[5'(30 + k)]);
    end

    // R9: three-wire mode
    wr(5'd0, 2'd0, 32'h80, 1'b0);
    chk("R9 mode bit in register 0", cfg_ctrl, 8'h80);
    read_sweep(1'b0, 1'b1);

    // R5: LSB-first, written in MSB order, effective next transaction
    wr(5'd0, 2'd0, 32'hC0, 1'b0);
    read_sweep(1'b1, 1'b1);
    wr(5'd12, 2'd0, 32'hA5, 1'b1);
    core_get(5'd12, v);
    chk("R5 LSB-first write lands", v, 8'hA5);
    wr(5'd0, 2'd0, 32'h40, 1'b1);
    rd_chk(5'd11, 2'd2, 1'b1, 1'b0);
    wr(5'd0, 2'd0, 32'h00, 1'b1);
    chk("R5 back to MSB-first", cfg_ctrl, 8'h00);
    rd_chk(5'd0, 2'd1, 1'b0, 1'b0);

    // R7: per-byte commit while chip select stays low
    sel();
    put_byte({1'b0, 2'd1, 5'd8}, 1'b0);
    put_byte(8'h5A, 1'b0);
    repeat (6) @(negedge clk);
    core_get(5'd8, v);
    chk("R7 first byte committed mid-transfer", v, 8'h5A);
    core_get(5'd9, v);
    chk("R7 second register untouched yet", v, model[9]);
    put_byte(8'hC3, 1'b0);
    repeat (6) @(negedge clk);
    core_get(5'd9, v);
    chk("R7 second byte committed before deselect", v, 8'hC3);
    desel();
    model[8] = 8'h5A;
    model[9] = 8'hC3;

    // R6: abort in data phase, then abort in command phase
    sel();
    put_byte({1'b0, 2'd0, 5'd5}, 1'b0);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    desel();
    core_get(5'd5, v);
    chk("R6 partial byte discarded", v, model[5]);
    sel();
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    desel();
    wr(5'd5, 2'd0, 32'h99, 1'b0);
    core_get(5'd5, v);
    chk("R6 fresh command after abort", v, 8'h99);
    core_get(5'd31, v);
    chk("R6 no stray write after aborted command", v, model[31]);

    // R2: extra clocks after the data phase are ignored
    sel();
    put_byte({1'b0, 2'd0, 5'd14}, 1'b0);
    put_byte(8'h3C, 1'b0);
    put_byte(8'h77, 1'b0);
    put_byte(8'h11, 1'b0);
    desel();
    model[14] = 8'h3C;
    core_get(5'd14, v);
    chk("R2 single byte written", v, 8'h3C);
    core_get(5'd15, v);
    chk("R2 excess bits ignored at next address", v, model[15]);
    core_get(5'd16, v);
    chk("R2 excess bits ignored further on", v, model[16]);

    // R8: deselect in the middle of a read drops the drive
    sel();
    put_byte({1'b1, 2'd3, 5'd2}, 1'b0);
    repeat (4) @(negedge clk);
    chk("R4 drive starts after command byte", sdo_oe, 1);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 enables low once deselected", {sdio_oe, sdo_oe}, 0);
    repeat (6) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule